// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Condition Codes

This block is the arithmetic stage of a small accumulator machine with two 8-bit accumulators and a 16-bit index register. Each cycle it takes a 4-bit operation code, both accumulators, an index value and a 16-bit operand (memory data or an immediate, already fetched). It returns the arithmetic result and the condition code byte that the operation would produce. Fetch, decode and memory traffic stay with the surrounding core.

The condition code byte is held in a register inside the block. This register is the carry source for the carry-chained operations. When the load enable is high, the register takes the newly computed byte at the next rising clock edge. For 16-bit work the two accumulators are joined into one double accumulator, with the first accumulator as the high byte.

Top module: `acc_alu`

## Requirements
- R1: The condition code byte has these bit positions: bit 7 stop-disable, bit 6 non-maskable interrupt mask, bit 5 half carry (H), bit 4 interrupt mask, bit 3 negative (N), bit 2 zero (Z), bit 1 overflow (V), bit 0 carry (C). While reset is low, `ccr_o` holds 0xD0.
- R2: Op 0 adds the operand's low byte to accumulator A and op 4 adds it to accumulator B. Both update N (result bit 7), Z (result all zero), V (signed overflow), C (carry out of bit 7) and H (carry out of bit 3).
- R3: Op 1 computes A plus the operand plus the registered C, and op 5 does the same for B. The flags follow R2.
- R4: Op 2 computes A minus the operand and op 6 computes B minus the operand. Op 3 computes A minus the operand minus the registered C, and op 7 does the same for B. These four ops update N, Z, V and C, with C set on a borrow, and leave H unchanged.
- R5: Op 8 computes A+B and updates N, Z, V, C and H as in R2. Op 9 computes A−B and updates flags as in R4.
- R6: Op 10 adds B, zero-extended to 16 bits, to the index input and gives a 16-bit result. It leaves the condition code byte unchanged.
- R7: Op 11 computes A−1 and updates N, Z and V. It leaves C and H unchanged.
- R8: Op 12 computes D+operand and op 13 computes D−operand, where D is A in the high byte and B in the low byte. Both are 16-bit operations. They set N from bit 15, Z over 16 bits, V for signed 16-bit overflow and C for carry or borrow out of bit 15, and leave H unchanged.
- R9: No operation ever changes bits 7, 6 or 4 of the condition code byte.
- R10: On a rising edge with `ccr_load_i` high, `ccr_o` takes the value `ccr_next_o` had before that edge. With `ccr_load_i` low, `ccr_o` holds its value.
- R11: Op codes 14 and 15 give a zero result and leave the condition code byte unchanged.
- R12: Every 8-bit operation drives zero on result bits 15 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the condition code register updates on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation code (see requirements) |
| acc_a_i | input | 8 | Accumulator A; high byte of D |
| acc_b_i | input | 8 | Accumulator B; low byte of D |
| idx_i | input | 16 | Index register value for op 10 |
| opnd_i | input | 16 | Memory or immediate operand; 8-bit ops use the low byte |
| ccr_load_i | input | 1 | Write `ccr_next_o` into the condition code register |
| result_o | output | 16 | Operation result |
| ccr_next_o | output | 8 | Condition code byte produced by the current operation |
| ccr_o | output | 8 | Registered condition code byte |

## Verification
The bench sweeps every pair of A and operand values for both carry-chained 8-bit operations, with the registered carry alternating at random. A carry-in that is dropped or inverted, or a borrow taken with the wrong polarity, therefore shows up on roughly half of all vectors. Directed vectors target the signed-overflow points 0x7F+1, 0x80−1 and decrement of 0x80, where a V taken from the unsigned carry is wrong. They also cover 0xFFFF+1 on D, where a carry chain cut at bit 7 gives a nonzero result or a lost C. A randomised pass over every op code with boundary-biased operands looks for four more faults: H updated by subtract or decrement, C touched by decrement, flags touched by the index add, and a nonzero upper byte on 8-bit results.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD_A      = 4'd0,
        OP_ADC_A      = 4'd1,
        OP_SUB_A      = 4'd2,
        OP_SBC_A      = 4'd3,
        OP_ADD_B      = 4'd4,
        OP_ADC_B      = 4'd5,
        OP_SUB_B      = 4'd6,
        OP_SBC_B      = 4'd7,
        OP_A_PLUS_B   = 4'd8,
        OP_A_MINUS_B  = 4'd9,
        OP_IDX_PLUS_B = 4'd10,
        OP_DEC_A      = 4'd11,
        OP_ADD_D      = 4'd12,
        OP_SUB_D      = 4'd13
    } alu_op_e;

    // Bit order is fixed: the surrounding core decodes these positions.
    typedef struct packed {
        logic stop_mask;
        logic xint_mask;
        logic half;
        logic int_mask;
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } ccr_t;

    localparam ccr_t CCR_RESET = ccr_t'(8'hD0);

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W-1:0] b_x;
    logic [W:0]   ext;

    always_comb begin
        b_x    = sub_i ? ~b_i : b_i;
        ext    = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, sub_i ^ cin_i};
        sum_o  = ext[W-1:0];
        cout_o = sub_i ? ~ext[W] : ext[W];
        ovf_o  = (sub_i ? (a_i[W-1] ^ b_i[W-1]) : ~(a_i[W-1] ^ b_i[W-1]))
               & (ext[W-1] ^ a_i[W-1]);
    end
endmodule

// File: rtl/acc_alu_ccr_reg.sv
module acc_alu_ccr_reg
    import acc_alu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  ccr_t next_i,
    output ccr_t q_o
);
    ccr_t ccr_d, ccr_q;

    always_comb begin
        ccr_d = load_i ? next_i : ccr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ccr_q <= CCR_RESET;
        else        ccr_q <= ccr_d;
    end

    assign q_o = ccr_q;

    a_r10_load_takes_next: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (ccr_q == $past(next_i)));
    a_r10_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(ccr_q));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3:0]            op_i,
    input  logic [BYTE_W-1:0]     acc_a_i,
    input  logic [BYTE_W-1:0]     acc_b_i,
    input  logic [2*BYTE_W-1:0]   idx_i,
    input  logic [2*BYTE_W-1:0]   opnd_i,
    input  logic                  ccr_load_i,
    output logic [2*BYTE_W-1:0]   result_o,
    output logic [7:0]            ccr_next_o,
    output logic [7:0]            ccr_o
);
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int HALF_BIT = BYTE_W / 2;

    alu_op_e             op;
    ccr_t                ccr_q, ccr_nx;
    logic [BYTE_W-1:0]   a8, b8, sum8;
    logic                cin8, sub8, c8, v8, half8;
    logic [WORD_W-1:0]   a16, b16, sum16;
    logic                sub16, c16, v16;
    logic                is_byte_op;

    // Operand steering
    always_comb begin
        op    = alu_op_e'(op_i);
        a8    = acc_a_i;
        b8    = opnd_i[BYTE_W-1:0];
        cin8  = 1'b0;
        sub8  = 1'b0;
        a16   = {acc_a_i, acc_b_i};
        b16   = opnd_i;
        sub16 = 1'b0;
        case (op)
            OP_ADC_A:      cin8 = ccr_q.carry;
            OP_SUB_A:      sub8 = 1'b1;
            OP_SBC_A:      begin sub8 = 1'b1; cin8 = ccr_q.carry; end
            OP_ADD_B:      a8 = acc_b_i;
            OP_ADC_B:      begin a8 = acc_b_i; cin8 = ccr_q.carry; end
            OP_SUB_B:      begin a8 = acc_b_i; sub8 = 1'b1; end
            OP_SBC_B:      begin a8 = acc_b_i; sub8 = 1'b1; cin8 = ccr_q.carry; end
            OP_A_PLUS_B:   b8 = acc_b_i;
            OP_A_MINUS_B:  begin b8 = acc_b_i; sub8 = 1'b1; end
            OP_DEC_A:      begin b8 = {{(BYTE_W-1){1'b0}}, 1'b1}; sub8 = 1'b1; end
            OP_IDX_PLUS_B: begin a16 = idx_i; b16 = {{BYTE_W{1'b0}}, acc_b_i}; end
            OP_SUB_D:      sub16 = 1'b1;
            default:       ;
        endcase
    end

    acc_alu_addsub #(.W(BYTE_W)) u_byte (
        .a_i(a8), .b_i(b8), .cin_i(cin8), .sub_i(sub8),
        .sum_o(sum8), .cout_o(c8), .ovf_o(v8)
    );

    acc_alu_addsub #(.W(WORD_W)) u_word (
        .a_i(a16), .b_i(b16), .cin_i(1'b0), .sub_i(sub16),
        .sum_o(sum16), .cout_o(c16), .ovf_o(v16)
    );

    assign half8 = a8[HALF_BIT] ^ b8[HALF_BIT] ^ sum8[HALF_BIT];

    // Result and flag selection
    always_comb begin
        ccr_nx     = ccr_q;
        result_o   = '0;
        is_byte_op = 1'b0;
        case (op)
            OP_ADD_A, OP_ADC_A, OP_ADD_B, OP_ADC_B, OP_A_PLUS_B: begin
                is_byte_op   = 1'b1;
                result_o     = {{BYTE_W{1'b0}}, sum8};
                ccr_nx.neg   = sum8[BYTE_W-1];
                ccr_nx.zero  = (sum8 == '0);
                ccr_nx.ovf   = v8;
                ccr_nx.carry = c8;
                ccr_nx.half  = half8;
            end
            OP_SUB_A, OP_SBC_A, OP_SUB_B, OP_SBC_B, OP_A_MINUS_B: begin
                is_byte_op   = 1'b1;
                result_o     = {{BYTE_W{1'b0}}, sum8};
                ccr_nx.neg   = sum8[BYTE_W-1];
                ccr_nx.zero  = (sum8 == '0);
                ccr_nx.ovf   = v8;
                ccr_nx.carry = c8;
            end
            OP_DEC_A: begin
                is_byte_op   = 1'b1;
                result_o     = {{BYTE_W{1'b0}}, sum8};
                ccr_nx.neg   = sum8[BYTE_W-1];
                ccr_nx.zero  = (sum8 == '0);
                ccr_nx.ovf   = v8;
            end
            OP_IDX_PLUS_B: result_o = sum16;
            OP_ADD_D, OP_SUB_D: begin
                result_o     = sum16;
                ccr_nx.neg   = sum16[WORD_W-1];
                ccr_nx.zero  = (sum16 == '0);
                ccr_nx.ovf   = v16;
                ccr_nx.carry = c16;
            end
            default: ;
        endcase
    end

    acc_alu_ccr_reg u_ccr (
        .clk(clk), .rst_n(rst_n), .load_i(ccr_load_i),
        .next_i(ccr_nx), .q_o(ccr_q)
    );

    assign ccr_next_o = ccr_nx;
    assign ccr_o      = ccr_q;

    a_r2_zero_matches_byte: assert property (@(posedge clk) disable iff (!rst_n)
        is_byte_op |-> (ccr_next_o[2] == (result_o[BYTE_W-1:0] == '0)));
    a_r12_upper_byte_clear: assert property (@(posedge clk) disable iff (!rst_n)
        is_byte_op |-> (result_o[WORD_W-1:BYTE_W] == '0));
    a_r6_index_add_keeps_ccr: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd10) |-> (ccr_next_o == ccr_o));
    a_r7_dec_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd11) |-> (ccr_next_o[0] == ccr_o[0] && ccr_next_o[5] == ccr_o[5]));
    a_r11_spare_codes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd14) |-> (result_o == '0 && ccr_next_o == ccr_o));
    a_r9_mask_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable({ccr_o[7:6], ccr_o[4]}));
endmodule

// File: tb/sim_acc_alu.sv
`timescale 1ns/100ps
module sim_acc_alu;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  op_i;
    logic [7:0]  acc_a_i, acc_b_i;
    logic [15:0] idx_i, opnd_i;
    logic        ccr_load_i;
    logic [15:0] result_o;
    logic [7:0]  ccr_next_o, ccr_o;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;
    logic [7:0] exp_ccr = 8'hD0;

    always #2.5 clk = ~clk;

    acc_alu u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_a_i(acc_a_i), .acc_b_i(acc_b_i),
        .idx_i(idx_i), .opnd_i(opnd_i), .ccr_load_i(ccr_load_i),
        .result_o(result_o), .ccr_next_o(ccr_next_o), .ccr_o(ccr_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int op);
        case (op)
            0, 4:          return "R2";
            1, 5:          return "R3";
            2, 3, 6, 7:    return "R4";
            8, 9:          return "R5";
            10:            return "R6";
            11:            return "R7";
            12, 13:        return "R8";
            default:       return "R11";
        endcase
    endfunction

    // Arithmetic reference in signed and unsigned integers: {result, ccr}
    function automatic logic [23:0] ref_model(input int op, input int a, input int b,
                                              input int idx, input int opnd,
                                              input logic [7:0] cc);
        logic [7:0]  n = cc;
        logic [15:0] res = 16'h0;
        int x, y, ci, r, sx, sy, sr;
        bit sub;
        if (op <= 9 || op == 11) begin
            x   = (op >= 4 && op <= 7) ? b : a;
            y   = (op == 8 || op == 9) ? b : (op == 11) ? 1 : (opnd & 255);
            ci  = (op == 1 || op == 3 || op == 5 || op == 7) ? int'(cc[0]) : 0;
            sub = (op == 2 || op == 3 || op == 6 || op == 7 || op == 9 || op == 11);
            r   = sub ? x - y - ci : x + y + ci;
            sx  = (x > 127) ? x - 256 : x;
            sy  = (y > 127) ? y - 256 : y;
            sr  = sub ? sx - sy - ci : sx + sy + ci;
            res = 16'(r & 255);
            n[3] = res[7];
            n[2] = (res == 0);
            n[1] = (sr > 127 || sr < -128);
            if (op != 11) n[0] = sub ? (r < 0) : (r > 255);
            if (!sub) n[5] = ((x & 15) + (y & 15) + ci) > 15;
        end else if (op == 10) begin
            res = 16'((idx + b) & 65535);
        end else if (op == 12 || op == 13) begin
            x   = a * 256 + b;
            y   = opnd;
            sub = (op == 13);
            r   = sub ? x - y : x + y;
            sx  = (x > 32767) ? x - 65536 : x;
            sy  = (y > 32767) ? y - 65536 : y;
            sr  = sub ? sx - sy : sx + sy;
            res = 16'(r & 65535);
            n[3] = res[15];
            n[2] = (res == 0);
            n[1] = (sr > 32767 || sr < -32768);
            n[0] = sub ? (r < 0) : (r > 65535);
        end
        return {res, n};
    endfunction

    task automatic step(input int op, input int a, input int b, input int idx,
                        input int opnd, input bit ld);
        logic [23:0] e;
        @(negedge clk);
        op_i = 4'(op); acc_a_i = 8'(a); acc_b_i = 8'(b);
        idx_i = 16'(idx); opnd_i = 16'(opnd); ccr_load_i = ld;
        #1;
        chk("R10", "registered ccr", {8'h0, ccr_o}, {8'h0, exp_ccr});
        chk("R9", "mask bits", {8'h0, ccr_o & 8'hD0}, 16'h00D0);
        e = ref_model(op, a, b, idx, opnd, exp_ccr);
        chk(req_of(op), "result", result_o, e[23:8]);
        chk(req_of(op), "next ccr", {8'h0, ccr_next_o}, {8'h0, e[7:0]});
        if (op <= 9 || op == 11)
            chk("R12", "upper byte", {8'h0, result_o[15:8]}, 16'h0);
        if (ld) exp_ccr = e[7:0];
    endtask

    function automatic int pick8();
        int edges[7] = '{0, 1, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hFF};
        if ($urandom % 3 == 0) return edges[$urandom % 7];
        return int'($urandom % 256);
    endfunction

    function automatic int pick16();
        int edges[6] = '{0, 1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h00FF};
        if ($urandom % 3 == 0) return edges[$urandom % 6];
        return int'($urandom % 65536);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual not finished expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; op_i = '0; acc_a_i = '0; acc_b_i = '0;
        idx_i = '0; opnd_i = '0; ccr_load_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset ccr", {8'h0, ccr_o}, 16'h00D0);
        rst_n = 1'b1;

        // Directed corner cases
        step(0, 8'h7F, 0, 0, 1, 1);          // R2 signed overflow, half carry
        step(4, 0, 8'hFF, 0, 1, 1);          // R2 carry and zero
        step(2, 8'h80, 0, 0, 1, 1);          // R4 signed overflow on subtract
        step(2, 0, 0, 0, 1, 1);              // R4 borrow sets C
        step(3, 5, 0, 0, 5, 1);              // R4 subtract with borrow in
        step(1, 0, 0, 0, 0, 1);              // R3 carry consumed
        step(11, 8'h80, 0, 0, 0, 1);         // R7 overflow on decrement
        step(11, 0, 0, 0, 0, 1);             // R7 wraps, C untouched
        step(12, 8'hFF, 8'hFF, 0, 1, 1);     // R8 0xFFFF+1
        step(13, 8'h80, 0, 0, 1, 1);         // R8 0x8000-1
        step(10, 0, 8'hFF, 16'hFFFF, 0, 1);  // R6 wraps, ccr unchanged
        step(8, 8'h0F, 8'h01, 0, 0, 1);      // R5 half carry
        step(9, 8'h00, 8'h01, 0, 0, 1);      // R5 borrow
        step(14, 8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, 1); // R11
        step(15, 1, 1, 1, 1, 1);             // R11
        step(0, 1, 1, 0, 1, 0);              // R10 no load keeps ccr

        // Full sweep of carry-chained byte ops with random registered carry
        for (int a = 0; a < 256; a++)
            for (int o = 0; o < 256; o++)
                step(1, a, pick8(), 0, o, bit'($urandom % 2));
        for (int a = 0; a < 256; a++)
            for (int o = 0; o < 256; o++)
                step(3, a, pick8(), 0, o, bit'($urandom % 2));

        // Randomised pass over every op code
        for (int k = 0; k < 1500; k++)
            for (int op = 0; op < 16; op++)
                step(op, pick8(), pick8(), pick16(), pick16(), bit'($urandom % 2));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule